// File: doc/BRIEF.md
# Three-Channel Event Timer with Interrupt Steering

This block keeps a 64-bit free-running count of a slow reference signal. The reference arrives as a plain level from another clock domain. It is re-timed into the fast system clock by a flop chain, and an edge detector turns each rising edge into a one-cycle advance strobe. The spacing of these strobes is uneven, but over time their rate equals the reference rate exactly. Three comparator channels watch the count. When the count steps onto a channel's programmed value, the channel sets a sticky status flag. If the channel's interrupt is enabled, the flag also drives an interrupt line.

Channel 0 can compare either the full 64 bits or only the low 32 bits. Channels 1 and 2 always compare 32 bits, so they fire again each time the low word wraps back to their value. Each channel steers its request to one of four shared lines (system lines 20 to 23). A legacy-steering control takes channels 0 and 1 off those lines and sends them to fixed outputs. While it is set, the block also raises two quiet signals that mute the old interval timer and the real-time clock.

Software reaches the block through a word-addressed port with 4-bit addresses and 32-bit data. A read returns its data one cycle later on `rdata`, and `rdata` holds that value until the next read.

Top module: `evt_timer`

## Requirements
- R1: While the run bit (bit 0 at address 0x0) is 1, the count rises by exactly 1 for each rising edge of `ref_tick_in`. Each edge passes through a two-flop synchronizer and an edge detector, so no edge advances the count twice.
- R2: While the run bit is 0, the count holds its value. Writes to address 0x2 replace the low word and writes to address 0x3 replace the high word. While the run bit is 1, writes to 0x2 and 0x3 are ignored.
- R3: Reading address 0x2 returns the low count word and, in the same cycle, captures the high word. A later read of address 0x3 returns the captured high word, even if the count has since carried into the high word. Read data appears on `rdata` one cycle after `rd_en`.
- R4: When the count advances onto a channel's compare value, status bit i at address 0x1 sets and stays set. Writing 1 to that bit clears it. The channel drives its line only while its interrupt-enable bit (bit 0 of its config word) is 1; the status bit sets either way.
- R5: A channel in 32-bit mode compares only the low 32 bits, so it fires again after the count passes a multiple of 2^32. Channel 0 with its width bit (config bit 1) at 1 compares all 64 bits.
- R6: Channels 1 and 2 are 32-bit only. Their width bit always reads 0, even after a write of 1. Only channel 0 has an upper compare word, at address 0x9.
- R7: The hardware never changes a compare register. Each one reads back the value last written: channel 0 low at 0x8, channel 0 high at 0x9, channel 1 at 0xA, channel 2 at 0xB.
- R8: With legacy steering off, a channel whose route field (config bits 3:2) holds k drives bit k of `irq_lines`, which is system line 20+k. Requests from channels that share a line are ORed together. Config words sit at 0x4, 0x5 and 0x6 for channels 0, 1 and 2.
- R9: With legacy steering on (bit 1 at address 0x0), channel 0 drives both `irq_pic_tmr` and `irq_apic_tmr`, channel 1 drives `irq_rtc_slot`, and neither of them reaches `irq_lines`. Channel 2 keeps using its route field. `pit_quiet` and `rtc_quiet` are both 1.
- R10: After reset, every register reads 0, channel 0 is in 32-bit mode, `rdata` is 0 and every interrupt and quiet output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_in | input | 1 | Slow reference signal, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_lines | output | 4 | Shared interrupt lines 20..23 |
| irq_pic_tmr | output | 1 | Legacy timer request toward the 8259 input 0 |
| irq_apic_tmr | output | 1 | Legacy timer request toward the APIC input 2 |
| irq_rtc_slot | output | 1 | Legacy request on line 8 |
| pit_quiet | output | 1 | Mutes the old interval timer interrupt |
| rtc_quiet | output | 1 | Mutes the real-time clock interrupt |

## Verification
Three patterns exercise the compare function.

- **Plain match.** All channels match the same small value after a few reference edges with every interrupt enable off. This separates setting the status flags from driving the lines.
- **Wrap and width.** The count is preloaded to 0x1_00000004 and then steps once. Channel 1 fires while channel 0 in 64-bit mode does not, so this shows whether the high word is being compared. Two more runs from the same start then show that channel 0 fires with an upper compare word of 0 in 32-bit mode, and with an upper word of 1 in 64-bit mode.
- **Steering vectors.** A table of route and legacy settings is applied over fixed status flags. Shared lines, ORing, masking by the enable bits, and the legacy override are each checked against the expected line pattern.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int NUM_CH    = 3;
    localparam int NUM_LINES = 4;
    localparam int ROUTE_W   = $clog2(NUM_LINES);
    localparam int ADDR_W    = 4;

    localparam logic [ADDR_W-1:0] A_CTRL    = 4'h0;
    localparam logic [ADDR_W-1:0] A_STAT    = 4'h1;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'h2;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'h3;
    localparam logic [ADDR_W-1:0] A_CFG_B   = 4'h4;
    localparam logic [ADDR_W-1:0] A_CMP0_LO = 4'h8;
    localparam logic [ADDR_W-1:0] A_CMP0_HI = 4'h9;

    typedef struct packed {
        logic [ROUTE_W-1:0] route;
        logic               wide;
        logic               int_en;
    } ch_cfg_t;

    localparam int CFG_W = $bits(ch_cfg_t);

    function automatic logic [ADDR_W-1:0] cfg_addr(input int ch);
        return A_CFG_B + ADDR_W'(ch);
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_lo_addr(input int ch);
        return (ch == 0) ? A_CMP0_LO : (A_CMP0_HI + ADDR_W'(ch));
    endfunction

endpackage

// File: rtl/evt_tick_sync.sv
module evt_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic tick
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], ref_in};
        st_d.last = st_q.sync[STAGES-1];
        tick      = st_q.sync[STAGES-1] & ~st_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_timer_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter int NARROW_W = 32,
    parameter bit WIDE_OK  = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic [CNT_W-1:0]    cnt_nxt,
    input  logic                cfg_we,
    input  logic                cmp_lo_we,
    input  logic                cmp_hi_we,
    input  logic [NARROW_W-1:0] wdata,
    input  logic                stat_clr,
    output ch_cfg_t             cfg_o,
    output logic [CNT_W-1:0]    cmp_o,
    output logic                stat_o,
    output logic                req_o
);
    localparam int HI_W = CNT_W - NARROW_W;

    typedef struct packed {
        ch_cfg_t          cfg;
        logic [CNT_W-1:0] cmp;
        logic             stat;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   hit;

    generate
        if (WIDE_OK) begin : g_wide
            always_comb begin
                if (st_q.cfg.wide)
                    hit = adv && (cnt_nxt == st_q.cmp);
                else
                    hit = adv && (cnt_nxt[NARROW_W-1:0] == st_q.cmp[NARROW_W-1:0]);
            end
        end else begin : g_narrow
            always_comb begin
                hit = adv && (cnt_nxt[NARROW_W-1:0] == st_q.cmp[NARROW_W-1:0]);
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.cfg = ch_cfg_t'(wdata[CFG_W-1:0]);
            if (!WIDE_OK) st_d.cfg.wide = 1'b0;
        end
        if (cmp_lo_we)
            st_d.cmp[NARROW_W-1:0] = wdata;
        if (cmp_hi_we && WIDE_OK)
            st_d.cmp[CNT_W-1:NARROW_W] = wdata[HI_W-1:0];
        if (stat_clr)
            st_d.stat = 1'b0;
        if (hit)
            st_d.stat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o  = st_q.cfg;
    assign cmp_o  = st_q.cmp;
    assign stat_o = st_q.stat;
    assign req_o  = st_q.stat & st_q.cfg.int_en;
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router
    import evt_timer_pkg::*;
(
    input  logic                            legacy,
    input  logic [NUM_CH-1:0]               req,
    input  logic [NUM_CH-1:0][ROUTE_W-1:0]  route,
    output logic [NUM_LINES-1:0]            lines,
    output logic                            pic_tmr,
    output logic                            apic_tmr,
    output logic                            rtc_slot,
    output logic                            pit_quiet,
    output logic                            rtc_quiet
);
    always_comb begin
        lines = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (!(legacy && (ch < 2)))
                lines[route[ch]] = lines[route[ch]] | req[ch];
        end
        pic_tmr   = legacy & req[0];
        apic_tmr  = legacy & req[0];
        rtc_slot  = legacy & req[1];
        pit_quiet = legacy;
        rtc_quiet = legacy;
    end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int CNT_W       = 64,
    parameter int NARROW_W    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_tick_in,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NARROW_W-1:0]  wdata,
    output logic [NARROW_W-1:0]  rdata,
    output logic [NUM_LINES-1:0] irq_lines,
    output logic                 irq_pic_tmr,
    output logic                 irq_apic_tmr,
    output logic                 irq_rtc_slot,
    output logic                 pit_quiet,
    output logic                 rtc_quiet
);
    localparam int HI_W = CNT_W - NARROW_W;

    typedef struct packed {
        logic                run;
        logic                legacy;
        logic [CNT_W-1:0]    cnt;
        logic [HI_W-1:0]     hi_latch;
        logic [NARROW_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                           tick;
    logic                           adv;
    logic [CNT_W-1:0]               cnt_nxt;
    logic                           cnt_wr;
    logic [NUM_CH-1:0]              stat;
    logic [NUM_CH-1:0]              stat_clr;
    logic [NUM_CH-1:0]              req;
    logic [NUM_CH-1:0]              int_en;
    logic [NUM_CH-1:0][ROUTE_W-1:0] route;
    ch_cfg_t                        cfg [NUM_CH];
    logic [CNT_W-1:0]               cmp [NUM_CH];
    logic [NARROW_W-1:0]            rd_word;
    logic                           run_q;
    logic                           legacy_q;
    logic [CNT_W-1:0]               cnt_q;

    evt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_tick_in),
        .tick   (tick)
    );

    assign adv     = tick & st_q.run;
    assign cnt_nxt = st_q.cnt + CNT_W'(1);
    assign cnt_wr  = wr_en && ((addr == A_CNT_LO) || (addr == A_CNT_HI));

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
            logic cfg_we, lo_we, hi_we;
            assign cfg_we       = wr_en && (addr == cfg_addr(gi));
            assign lo_we        = wr_en && (addr == cmp_lo_addr(gi));
            assign hi_we        = wr_en && (gi == 0) && (addr == A_CMP0_HI);
            assign stat_clr[gi] = wr_en && (addr == A_STAT) && wdata[gi];

            evt_channel #(
                .CNT_W    (CNT_W),
                .NARROW_W (NARROW_W),
                .WIDE_OK  (gi == 0)
            ) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .adv       (adv),
                .cnt_nxt   (cnt_nxt),
                .cfg_we    (cfg_we),
                .cmp_lo_we (lo_we),
                .cmp_hi_we (hi_we),
                .wdata     (wdata),
                .stat_clr  (stat_clr[gi]),
                .cfg_o     (cfg[gi]),
                .cmp_o     (cmp[gi]),
                .stat_o    (stat[gi]),
                .req_o     (req[gi])
            );

            assign route[gi]  = cfg[gi].route;
            assign int_en[gi] = cfg[gi].int_en;
        end
    endgenerate

    evt_irq_router u_router (
        .legacy    (st_q.legacy),
        .req       (req),
        .route     (route),
        .lines     (irq_lines),
        .pic_tmr   (irq_pic_tmr),
        .apic_tmr  (irq_apic_tmr),
        .rtc_slot  (irq_rtc_slot),
        .pit_quiet (pit_quiet),
        .rtc_quiet (rtc_quiet)
    );

    // Read data selection
    always_comb begin
        rd_word = '0;
        case (addr)
            A_CTRL:    rd_word[1:0]        = {st_q.legacy, st_q.run};
            A_STAT:    rd_word[NUM_CH-1:0] = stat;
            A_CNT_LO:  rd_word             = st_q.cnt[NARROW_W-1:0];
            A_CNT_HI:  rd_word[HI_W-1:0]   = st_q.hi_latch;
            A_CMP0_LO: rd_word             = cmp[0][NARROW_W-1:0];
            A_CMP0_HI: rd_word[HI_W-1:0]   = cmp[0][CNT_W-1:NARROW_W];
            default:   rd_word             = '0;
        endcase
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (addr == cfg_addr(ch))
                rd_word[CFG_W-1:0] = cfg[ch];
            if ((ch > 0) && (addr == cmp_lo_addr(ch)))
                rd_word = cmp[ch][NARROW_W-1:0];
        end
    end

    // Next-state logic for control, counter and read path
    always_comb begin
        st_d = st_q;
        if (wr_en && (addr == A_CTRL)) begin
            st_d.run    = wdata[0];
            st_d.legacy = wdata[1];
        end
        if (adv) begin
            st_d.cnt = cnt_nxt;
        end else if (!st_q.run && wr_en) begin
            if (addr == A_CNT_LO) st_d.cnt[NARROW_W-1:0]     = wdata;
            if (addr == A_CNT_HI) st_d.cnt[CNT_W-1:NARROW_W] = wdata[HI_W-1:0];
        end
        if (rd_en) begin
            st_d.rdata = rd_word;
            if (addr == A_CNT_LO)
                st_d.hi_latch = st_q.cnt[CNT_W-1:NARROW_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata    = st_q.rdata;
    assign run_q    = st_q.run;
    assign legacy_q = st_q.legacy;
    assign cnt_q    = st_q.cnt;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
    parameter int CNT_W  = 64,
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              run,
    input logic              legacy,
    input logic              cnt_wr,
    input logic [CNT_W-1:0]  cnt,
    input logic [NUM_CH-1:0] stat,
    input logic [NUM_CH-1:0] stat_clr,
    input logic [NUM_CH-1:0] int_en,
    input logic [3:0]        irq_lines,
    input logic              irq_pic_tmr,
    input logic              irq_rtc_slot
);
    // R1: one advance per synchronized edge
    p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R1: running count steps by one on each advance strobe
    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R2: stopped count without a write keeps its value
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));

    // R4: a set status bit stays set unless cleared
    p_stat_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat != '0) |=> ((stat & $past(stat & ~stat_clr)) == $past(stat & ~stat_clr)));

    // R4: no enabled pending request means no line is driven
    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & int_en) == '0) |-> (irq_lines == 4'b0 && !irq_pic_tmr && !irq_rtc_slot));

    // R9: under legacy steering only channel 2 can reach the shared lines
    p_legacy_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy && !stat[2]) |-> (irq_lines == 4'b0));
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W), .NUM_CH(evt_timer_pkg::NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .run          (run_q),
    .legacy       (legacy_q),
    .cnt_wr       (cnt_wr),
    .cnt          (cnt_q),
    .stat         (stat),
    .stat_clr     (stat_clr),
    .int_en       (int_en),
    .irq_lines    (irq_lines),
    .irq_pic_tmr  (irq_pic_tmr),
    .irq_rtc_slot (irq_rtc_slot)
);

// File: tb/tb_evt_timer.sv
`timescale 1ns/1ps
module tb_evt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick_in = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq_lines;
    logic        irq_pic_tmr, irq_apic_tmr, irq_rtc_slot, pit_quiet, rtc_quiet;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    evt_timer dut (
        .clk(clk), .rst_n(rst_n), .ref_tick_in(ref_tick_in),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_lines(irq_lines), .irq_pic_tmr(irq_pic_tmr), .irq_apic_tmr(irq_apic_tmr),
        .irq_rtc_slot(irq_rtc_slot), .pit_quiet(pit_quiet), .rtc_quiet(rtc_quiet)
    );

    // Routing vectors: {legacy, cfg0, cfg1, cfg2, expected lines, expected {pic,apic,rtc}}
    localparam logic [19:0] VEC [8] = '{
        {1'b0, 4'd1,  4'd5,  4'd9,  4'b0111, 3'b000},
        {1'b0, 4'd13, 4'd13, 4'd8,  4'b1000, 3'b000},
        {1'b0, 4'd0,  4'd0,  4'd0,  4'b0000, 3'b000},
        {1'b1, 4'd1,  4'd1,  4'd13, 4'b1000, 3'b111},
        {1'b1, 4'd0,  4'd1,  4'd0,  4'b0000, 3'b001},
        {1'b1, 4'd1,  4'd0,  4'd5,  4'b0010, 3'b110},
        {1'b0, 4'd9,  4'd9,  4'd9,  4'b0100, 3'b000},
        {1'b1, 4'd0,  4'd0,  4'd0,  4'b0000, 3'b000}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ref_tick_in = 1'b1;
            repeat (4) @(negedge clk);
            ref_tick_in = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic set_cnt(input logic [31:0] hi, input logic [31:0] lo);
        wr(4'h2, lo);
        wr(4'h3, hi);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk("R10 rdata", rdata, 0);
        chk("R10 outputs", {irq_lines, irq_pic_tmr, irq_apic_tmr, irq_rtc_slot, pit_quiet, rtc_quiet}, 0);
        rd(4'h0, d); chk("R10 ctrl", d, 0);
        rd(4'h2, d); chk("R10 cnt", d, 0);
        rd(4'h4, d); chk("R10 cfg0 narrow", d, 0);
        rd(4'h8, d); chk("R10 cmp0", d, 0);

        // R2: stopped counter accepts writes and ignores edges
        set_cnt(32'h0, 32'h10);
        pulses(3);
        rd(4'h2, d); chk("R2 hold while stopped", d, 32'h10);

        // R1: one step per edge
        wr(4'h0, 32'h1);
        pulses(5);
        rd(4'h2, d); chk("R1 five edges", d, 32'h15);
        wr(4'h2, 32'h999);
        rd(4'h2, d); chk("R2 write ignored while running", d, 32'h15);
        pulses(1);
        rd(4'h2, d); chk("R1 one more edge", d, 32'h16);
        wr(4'h0, 32'h0);

        // R3: coherent 64-bit read
        set_cnt(32'h0, 32'hFFFF_FFFF);
        wr(4'h0, 32'h1);
        rd(4'h2, d); chk("R3 low word", d, 32'hFFFF_FFFF);
        pulses(1);
        rd(4'h3, d); chk("R3 captured high word", d, 32'h0);
        rd(4'h2, d); chk("R3 low after carry", d, 32'h0);
        rd(4'h3, d); chk("R3 high after carry", d, 32'h1);
        wr(4'h0, 32'h0);

        // R4: matches with interrupts disabled
        set_cnt(32'h0, 32'h0);
        wr(4'h8, 32'h3); wr(4'h9, 32'h0); wr(4'hA, 32'h3); wr(4'hB, 32'h3);
        wr(4'h4, 32'h0); wr(4'h5, 32'h0); wr(4'h6, 32'h0);
        wr(4'h0, 32'h1);
        pulses(3);
        wr(4'h0, 32'h0);
        rd(4'h1, d); chk("R4 status set on match", d, 32'h7);
        chk("R4 no line while disabled", {irq_lines, irq_pic_tmr, irq_rtc_slot}, 0);

        // R7: comparators unchanged by the hardware
        rd(4'hA, d); chk("R7 cmp1 readback", d, 32'h3);
        rd(4'h8, d); chk("R7 cmp0 readback", d, 32'h3);

        // R8 / R9: routing vectors over fixed status flags
        for (int v = 0; v < 8; v++) begin
            wr(4'h0, {30'b0, VEC[v][19], 1'b0});
            wr(4'h4, {28'b0, VEC[v][18:15]});
            wr(4'h5, {28'b0, VEC[v][14:11]});
            wr(4'h6, {28'b0, VEC[v][10:7]});
            chk(VEC[v][19] ? "R9 lines" : "R8 lines", irq_lines, VEC[v][6:3]);
            chk("R9 legacy outputs", {irq_pic_tmr, irq_apic_tmr, irq_rtc_slot}, VEC[v][2:0]);
            chk("R9 quiet", {pit_quiet, rtc_quiet}, {2{VEC[v][19]}});
        end

        // R4: write-one-to-clear
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h1);
        chk("R4 enabled line high", irq_lines, 4'b0001);
        wr(4'h1, 32'h2);
        rd(4'h1, d); chk("R4 clear ch1 only", d, 32'h5);
        wr(4'h1, 32'h1);
        chk("R4 line drops after clear", irq_lines, 4'b0000);
        wr(4'h1, 32'h7);

        // R6: narrow-only channels
        wr(4'h5, 32'h3);
        rd(4'h5, d); chk("R6 width bit forced 0", d, 32'h1);

        // R5: wrap and width
        wr(4'h4, 32'h3);
        wr(4'h5, 32'h5);
        wr(4'h8, 32'h5); wr(4'h9, 32'h0); wr(4'hA, 32'h5);
        set_cnt(32'h1, 32'h4);
        wr(4'h0, 32'h1); pulses(1); wr(4'h0, 32'h0);
        rd(4'h1, d); chk("R5 wide ch0 silent, narrow ch1 fires after wrap", d, 32'h2);
        chk("R5 ch1 line", irq_lines, 4'b0010);
        wr(4'h1, 32'h7);
        wr(4'h4, 32'h1);
        set_cnt(32'h1, 32'h4);
        wr(4'h0, 32'h1); pulses(1); wr(4'h0, 32'h0);
        rd(4'h1, d); chk("R5 narrow ch0 fires after wrap", d, 32'h3);
        wr(4'h1, 32'h7);
        wr(4'h4, 32'h3); wr(4'h9, 32'h1);
        set_cnt(32'h1, 32'h4);
        wr(4'h0, 32'h1); pulses(1); wr(4'h0, 32'h0);
        rd(4'h1, d); chk("R5 wide ch0 matches full value", d, 32'h3);
        rd(4'h9, d); chk("R7 cmp0 high readback", d, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule